// File: doc/BRIEF.md
# Bus Target Data-Phase Controller

This block is the control half of a target on a shared bus that carries address and data on the same lines. It captures the address during the single cycle in which the initiator presents it. It then decides whether, and when, to claim the access. The claim comes after a fast, medium or slow decode delay, or after a late catch-all slot when nothing else answers. Once the access is claimed, the block runs the data phases by pairing its own ready line with the initiator's ready line.

The block keeps the bus rules a target must obey. A read leaves one dead cycle on the shared lines before the target drives data. A ready or stop, once raised, stays up until its data phase closes. A burst ends on either side's request without wasted cycles. After the access, the control lines are parked inactive for one cycle before they are let go. A 64-bit address that arrives over two cycles is also decoded. The data path, configuration registers and parity live elsewhere; the local side only says when it has data ready and when it wants to stop.

Top module: `bus_tgt_ctrl`

## Requirements
- R1: An address phase is a cycle with `frame_i` high while the block is idle. In that cycle `ad_i` and `cmd_i` are captured, and from the next cycle `addr_o` shows them with the upper 32 bits zero and `cmd_o` shows the command.
- R2: If `addr_hit_i` is high in the final address cycle, `sel_o` rises in the 1st, 2nd or 3rd cycle after it for `speed_sel` 0, 1 or 2. The value 3 behaves like 2.
- R3: With `subtr_en` high and no hit, `sel_o` rises in the 4th cycle after the final address cycle. This happens only if `peer_sel_i` was low in cycles 1 to 3; otherwise the access is never claimed.
- R4: With no hit and `subtr_en` low, `sel_o`, `ctl_oe_o` and `trdy_o` stay low. The block then waits for a cycle with both `frame_i` and `irdy_i` low before it accepts a new address.
- R5: On a read (`cmd_i[0]` = 0), `ad_oe_o` is low in the first cycle after the final address cycle, even at fast timing. `trdy_o` is high on a read only while `ad_oe_o` is high.
- R6: Once `trdy_o` is high, it stays high until a cycle in which `irdy_i` is also high.
- R7: `xfer_o` is high in every cycle in which `irdy_i` and `trdy_o` are both high, so a word can move every clock. Each transfer raises `addr_o` by 4 from the next cycle.
- R8: `loc_stop_i` high during a claimed access raises `stop_o` in the next cycle. `stop_o` then holds until the access ends, and `trdy_o` is not raised again after the current data phase.
- R9: An access ends in a cycle with `frame_i` low, `irdy_i` high and `trdy_o` or `stop_o` high. A stop raised together with the initiator's last phase adds no cycle.
- R10: Command code 4'hD marks the first cycle of a dual address. The next cycle carries the upper 32 address bits and the real command, and decode delays count from that second cycle. If the upper bits are zero, the access is not claimed, even by the catch-all slot.
- R11: In the cycle after an access ends, `ctl_oe_o` is high while `sel_o`, `trdy_o` and `stop_o` are low. In the cycle after that, `ctl_oe_o` is low.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| speed_sel | input | 2 | Static decode speed: 0 fast, 1 medium, 2/3 slow |
| subtr_en | input | 1 | Static enable for the catch-all claim slot |
| frame_i | input | 1 | Initiator is framing an access (active high) |
| irdy_i | input | 1 | Initiator ready |
| cmd_i | input | 4 | Command; bit 0 = 1 write, 0 read; 4'hD dual address |
| ad_i | input | 32 | Shared address/data lines as seen by the target |
| addr_hit_i | input | 1 | Address decoder match for the final address cycle |
| peer_sel_i | input | 1 | Another target's select, observed on the bus |
| loc_rdy_i | input | 1 | Local side can complete a data phase |
| loc_stop_i | input | 1 | Local side asks to end the burst |
| sel_o | output | 1 | Device select (active high) |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Target stop request |
| ctl_oe_o | output | 1 | Drive enable for select, ready and stop |
| ad_oe_o | output | 1 | Drive enable for read data on the shared lines |
| xfer_o | output | 1 | A data word moves this cycle |
| addr_o | output | 64 | Captured address, advanced per word |
| cmd_o | output | 4 | Captured command |

## Verification
The bench steps through each select delay and checks the exact cycle in which select rises. A design that is off by one in its counter would claim in the wrong cycle, and this would show as a mismatch in that cycle. The fast read is checked for the dead turnaround cycle. A design that drove data or ready straight away would collide with the initiator's address drivers.

Other cases come from the local side and the initiator. The local side is made to go un-ready after its ready is raised, and the bench checks that ready is still held. A stop is issued both mid-burst and together with the initiator's last phase. A design that mishandled the second case would either add a cycle or drop the final word.

Two cases test the catch-all slot. In one, another target answers first. In the other, a dual-address access has zero upper bits. An over-eager catch-all target would claim either access.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DAC2,
    ST_DECODE,
    ST_DATA,
    ST_TURN,
    ST_MISS
  } bt_state_e;

  localparam int unsigned SLOT_W   = 3;
  localparam logic [SLOT_W-1:0] SUB_SLOT = 3'd4;
  localparam logic [SLOT_W-1:0] SUB_LAST = 3'd3;
  localparam logic [3:0]  CMD_DUAL = 4'hD;

  // Cycle after the address phase in which select is raised.
  function automatic logic [SLOT_W-1:0] sel_slot(input logic [1:0] spd);
    case (spd)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  function automatic logic cmd_is_read(input logic [3:0] c);
    return !c[0];
  endfunction

  function automatic int unsigned word_bytes(input int unsigned bus_w);
    return bus_w / 8;
  endfunction

endpackage

// File: rtl/bt_addr_cap.sv
module bt_addr_cap
  import bt_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CMD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_lo,
  input  logic              cap_hi,
  input  logic              step,
  input  logic [AD_W-1:0]   ad_in,
  input  logic [CMD_W-1:0]  cmd_in,
  output logic [2*AD_W-1:0] addr_o,
  output logic [CMD_W-1:0]  cmd_o
);

  localparam int FULL_W = 2 * AD_W;
  localparam logic [FULL_W-1:0] INC = FULL_W'(word_bytes(AD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o <= '0;
      cmd_o  <= '0;
    end else if (cap_lo) begin
      addr_o <= {{AD_W{1'b0}}, ad_in};
      cmd_o  <= cmd_in;
    end else if (cap_hi) begin
      addr_o <= {ad_in, addr_o[AD_W-1:0]};
      cmd_o  <= cmd_in;
    end else if (step) begin
      addr_o <= addr_o + INC;
    end
  end

endmodule

// File: rtl/bt_claim.sv
module bt_claim
  import bt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       hit,
  input  logic       legal,
  input  logic [1:0] spd,
  input  logic       subtr_en,
  input  logic       peer_sel,
  output logic       claim_go,
  output logic       give_up
);

  logic [SLOT_W-1:0] cnt;
  logic [SLOT_W-1:0] cnt_nx;
  logic              active;
  logic              hit_q;
  logic              legal_q;
  logic              peer_q;
  logic              peer_any;
  logic              pos_hit;
  logic              sub_hit;

  always_comb begin
    cnt_nx   = cnt + SLOT_W'(1);
    peer_any = peer_q | peer_sel;
    pos_hit  = hit_q && (cnt_nx == sel_slot(spd));
    sub_hit  = subtr_en && !hit_q && (cnt_nx == SUB_SLOT) && !peer_any;
    if (arm)
      claim_go = hit && legal && (sel_slot(spd) == SLOT_W'(1));
    else
      claim_go = active && legal_q && (pos_hit || sub_hit);
    give_up = active && !arm && !claim_go && (cnt == SUB_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      active  <= 1'b0;
      hit_q   <= 1'b0;
      legal_q <= 1'b0;
      peer_q  <= 1'b0;
    end else if (arm) begin
      cnt     <= SLOT_W'(1);
      active  <= !claim_go;
      hit_q   <= hit;
      legal_q <= legal;
      peer_q  <= 1'b0;
    end else if (active) begin
      cnt    <= cnt_nx;
      peer_q <= peer_any;
      if (claim_go || give_up) active <= 1'b0;
    end
  end

  // R3: once another target has answered, the catch-all slot is lost
  p_peer_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !arm && !hit_q && peer_sel) |=> !claim_go);

endmodule

// File: rtl/bt_phase.sv
module bt_phase
  import bt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  input  logic irdy,
  input  logic cmd_dual,
  input  logic claim_go,
  input  logic give_up,
  input  logic rd_now,
  input  logic loc_rdy,
  input  logic loc_stop,
  output logic arm,
  output logic cap_lo,
  output logic dac_cyc,
  output logic sel_o,
  output logic trdy_o,
  output logic stop_o,
  output logic ctl_oe_o,
  output logic ad_oe_o,
  output logic xfer,
  output logic txn_end
);

  bt_state_e st, st_nx;
  logic in_data_nx;
  logic hold_rdy;
  logic oe_nx;
  logic stop_nx;
  logic trdy_nx;

  // Named events for assertions and neighbours
  assign cap_lo  = (st == ST_IDLE) && frame;
  assign dac_cyc = (st == ST_DAC2);
  assign arm     = (cap_lo && !cmd_dual) || dac_cyc;
  assign xfer    = (st == ST_DATA) && irdy && trdy_o;
  assign txn_end = (st == ST_DATA) && !frame && irdy && (trdy_o || stop_o);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:   if (frame) st_nx = cmd_dual ? ST_DAC2 : (claim_go ? ST_DATA : ST_DECODE);
      ST_DAC2:   st_nx = claim_go ? ST_DATA : ST_DECODE;
      ST_DECODE: if (claim_go) st_nx = ST_DATA;
                 else if (give_up) st_nx = ST_MISS;
      ST_DATA:   if (txn_end) st_nx = ST_TURN;
      ST_TURN:   st_nx = ST_IDLE;
      ST_MISS:   if (!frame && !irdy) st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    in_data_nx = (st_nx == ST_DATA);
    hold_rdy   = trdy_o && !irdy;
    // read data may not be driven in the cycle right after the address
    oe_nx      = in_data_nx && rd_now && !arm;
    stop_nx    = in_data_nx && (stop_o || loc_stop);
    trdy_nx    = in_data_nx &&
                 (hold_rdy || (loc_rdy && !stop_nx && (!rd_now || oe_nx)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sel_o    <= 1'b0;
      trdy_o   <= 1'b0;
      stop_o   <= 1'b0;
      ctl_oe_o <= 1'b0;
      ad_oe_o  <= 1'b0;
    end else begin
      st       <= st_nx;
      sel_o    <= in_data_nx;
      trdy_o   <= trdy_nx;
      stop_o   <= stop_nx;
      ctl_oe_o <= in_data_nx || (st_nx == ST_TURN);
      ad_oe_o  <= oe_nx;
    end
  end

  // R5: turnaround cycle after the address keeps the data lines quiet
  p_turn_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !ad_oe_o);
  // R5: read ready never precedes read data
  p_rd_data_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_o && rd_now && !arm) |-> ad_oe_o);
  // R6: ready cannot be withdrawn before the phase completes
  p_rdy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_o && !irdy) |=> trdy_o);
  // R8: stop is sticky until the access ends
  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && !txn_end) |=> stop_o);
  // R8: no fresh ready once stop is up
  p_no_rdy_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && !trdy_o) |=> !trdy_o);
  // R11: one parked cycle with lines driven inactive
  p_park_r11: assert property (@(posedge clk) disable iff (!rst_n)
    txn_end |=> (ctl_oe_o && !sel_o && !trdy_o && !stop_o));

endmodule

// File: rtl/bus_tgt_ctrl.sv
module bus_tgt_ctrl
  import bt_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CMD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speed_sel,
  input  logic              subtr_en,
  input  logic              frame_i,
  input  logic              irdy_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [AD_W-1:0]   ad_i,
  input  logic              addr_hit_i,
  input  logic              peer_sel_i,
  input  logic              loc_rdy_i,
  input  logic              loc_stop_i,
  output logic              sel_o,
  output logic              trdy_o,
  output logic              stop_o,
  output logic              ctl_oe_o,
  output logic              ad_oe_o,
  output logic              xfer_o,
  output logic [2*AD_W-1:0] addr_o,
  output logic [CMD_W-1:0]  cmd_o
);

  logic arm;
  logic cap_lo;
  logic dac_cyc;
  logic legal;
  logic claim_go;
  logic give_up;
  logic rd_now;
  logic cmd_dual;
  logic txn_end;

  assign cmd_dual = (cmd_i == CMD_DUAL);
  assign legal    = !dac_cyc || (|ad_i);
  assign rd_now   = arm ? cmd_is_read(cmd_i) : cmd_is_read(cmd_o);

  bt_addr_cap #(.AD_W(AD_W), .CMD_W(CMD_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_lo (cap_lo),
    .cap_hi (dac_cyc),
    .step   (xfer_o),
    .ad_in  (ad_i),
    .cmd_in (cmd_i),
    .addr_o (addr_o),
    .cmd_o  (cmd_o)
  );

  bt_claim u_claim (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .hit      (addr_hit_i),
    .legal    (legal),
    .spd      (speed_sel),
    .subtr_en (subtr_en),
    .peer_sel (peer_sel_i),
    .claim_go (claim_go),
    .give_up  (give_up)
  );

  bt_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame    (frame_i),
    .irdy     (irdy_i),
    .cmd_dual (cmd_dual),
    .claim_go (claim_go),
    .give_up  (give_up),
    .rd_now   (rd_now),
    .loc_rdy  (loc_rdy_i),
    .loc_stop (loc_stop_i),
    .arm      (arm),
    .cap_lo   (cap_lo),
    .dac_cyc  (dac_cyc),
    .sel_o    (sel_o),
    .trdy_o   (trdy_o),
    .stop_o   (stop_o),
    .ctl_oe_o (ctl_oe_o),
    .ad_oe_o  (ad_oe_o),
    .xfer     (xfer_o),
    .txn_end  (txn_end)
  );

  // R2: fast decode claims right after the address
  p_fast_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && addr_hit_i && legal && speed_sel == 2'd0) |=> sel_o);
  // R10: a dual address with zero upper half is never claimed next cycle
  p_dac_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_cyc && ad_i == '0) |=> !sel_o);
  // R4: select is never up without control drive
  p_sel_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o |-> ctl_oe_o);

endmodule

// File: tb/bus_tgt_ctrl_tb_top.sv
module bus_tgt_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  speed_sel = 2'd0;
  logic        subtr_en = 1'b0;
  logic        frame_i = 1'b0;
  logic        irdy_i = 1'b0;
  logic [3:0]  cmd_i = 4'h0;
  logic [31:0] ad_i = '0;
  logic        addr_hit_i = 1'b0;
  logic        peer_sel_i = 1'b0;
  logic        loc_rdy_i = 1'b0;
  logic        loc_stop_i = 1'b0;
  logic        sel_o, trdy_o, stop_o, ctl_oe_o, ad_oe_o, xfer_o;
  logic [63:0] addr_o;
  logic [3:0]  cmd_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_tgt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .subtr_en(subtr_en),
    .frame_i(frame_i), .irdy_i(irdy_i), .cmd_i(cmd_i), .ad_i(ad_i),
    .addr_hit_i(addr_hit_i), .peer_sel_i(peer_sel_i), .loc_rdy_i(loc_rdy_i),
    .loc_stop_i(loc_stop_i), .sel_o(sel_o), .trdy_o(trdy_o), .stop_o(stop_o),
    .ctl_oe_o(ctl_oe_o), .ad_oe_o(ad_oe_o), .xfer_o(xfer_o),
    .addr_o(addr_o), .cmd_o(cmd_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Inputs for a cycle are set at its falling edge; outputs checked 1 ns later.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    frame_i = 0; irdy_i = 0; addr_hit_i = 0; peer_sel_i = 0;
    loc_rdy_i = 0; loc_stop_i = 0; cmd_i = 4'h0; ad_i = '0;
  endtask

  task automatic addr_phase(input logic [3:0] c, input logic [31:0] a,
                            input logic hit, input logic lrdy);
    tick(); frame_i = 1; irdy_i = 0; cmd_i = c; ad_i = a;
    addr_hit_i = hit; loc_rdy_i = lrdy;
  endtask

  // Initiator closes with one last phase; then check the parked cycle.
  task automatic wrap_up(input string req);
    for (int n = 0; n < 8; n++) begin
      tick(); frame_i = 0; irdy_i = 1; loc_rdy_i = 1; addr_hit_i = 0;
      #1;
      if (xfer_o) break;
    end
    tick(); quiet(); #1;
    chk(req, "R11 parked ctl_oe", ctl_oe_o, 1);
    chk(req, "R11 parked sel", sel_o, 0);
    chk(req, "R11 parked trdy", trdy_o, 0);
    tick(); #1;
    chk(req, "R11 released ctl_oe", ctl_oe_o, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R11", "reset sel", sel_o, 0);
    chk("R11", "reset trdy", trdy_o, 0);
    chk("R11", "reset stop", stop_o, 0);
    chk("R11", "reset ctl_oe", ctl_oe_o, 0);
    chk("R5", "reset ad_oe", ad_oe_o, 0);
  endtask

  task automatic t_latency(input logic [1:0] spd, input int lat);
    speed_sel = spd; subtr_en = 0;
    addr_phase(4'h7, 32'h1000_0040, 1, 0);
    for (int k = 1; k <= 4; k++) begin
      tick(); addr_hit_i = 0; ad_i = '0; #1;
      chk("R2", $sformatf("speed %0d sel at cycle %0d", spd, k), sel_o, k >= lat);
      if (k == 1) begin
        chk("R1", "captured address", addr_o, 64'h1000_0040);
        chk("R1", "captured command", cmd_o, 4'h7);
      end
    end
    wrap_up("R2");
  endtask

  task automatic t_subtractive();
    speed_sel = 2'd2; subtr_en = 1;
    addr_phase(4'h7, 32'h2000_0000, 0, 0);
    for (int k = 1; k <= 5; k++) begin
      tick(); #1;
      chk("R3", $sformatf("catch-all sel at cycle %0d", k), sel_o, k >= 4);
    end
    wrap_up("R3");
    addr_phase(4'h7, 32'h2000_0100, 0, 0);
    for (int k = 1; k <= 6; k++) begin
      tick(); peer_sel_i = (k == 2); #1;
      chk("R3", $sformatf("peer answered, sel at cycle %0d", k), sel_o, 0);
    end
    tick(); quiet(); tick(); #1;
    chk("R3", "peer answered, ctl_oe", ctl_oe_o, 0);
    subtr_en = 0;
  endtask

  task automatic t_unclaimed();
    speed_sel = 2'd0; subtr_en = 0;
    addr_phase(4'h6, 32'h3000_0000, 0, 1);
    for (int k = 1; k <= 6; k++) begin
      tick(); #1;
      chk("R4", $sformatf("no claim sel cycle %0d", k), sel_o, 0);
      chk("R4", $sformatf("no claim trdy cycle %0d", k), trdy_o, 0);
    end
    tick(); quiet(); tick(); #1;
    chk("R4", "no claim ctl_oe", ctl_oe_o, 0);
  endtask

  task automatic t_read_fast();
    speed_sel = 2'd0; subtr_en = 0;
    addr_phase(4'h6, 32'h0000_0800, 1, 1);
    tick(); addr_hit_i = 0; #1;
    chk("R5", "fast read sel in turnaround", sel_o, 1);
    chk("R5", "fast read ad_oe in turnaround", ad_oe_o, 0);
    chk("R5", "fast read trdy in turnaround", trdy_o, 0);
    tick(); #1;
    chk("R5", "fast read ad_oe after turnaround", ad_oe_o, 1);
    chk("R5", "fast read trdy after turnaround", trdy_o, 1);
    wrap_up("R5");
  endtask

  task automatic t_burst();
    speed_sel = 2'd0; subtr_en = 0;
    addr_phase(4'h7, 32'h0000_2000, 1, 1);
    for (int k = 1; k <= 3; k++) begin
      tick(); addr_hit_i = 0; frame_i = (k < 3); irdy_i = 1; loc_rdy_i = 1; #1;
      chk("R7", $sformatf("burst xfer word %0d", k), xfer_o, 1);
      chk("R7", $sformatf("burst address word %0d", k), addr_o,
          64'h2000 + 64'(4 * (k - 1)));
    end
    tick(); quiet(); #1;
    chk("R7", "address after burst", addr_o, 64'h200C);
    chk("R11", "burst parked ctl_oe", ctl_oe_o, 1);
    chk("R11", "burst parked sel", sel_o, 0);
    tick(); #1;
    chk("R11", "burst released ctl_oe", ctl_oe_o, 0);
  endtask

  task automatic t_hold();
    speed_sel = 2'd1; subtr_en = 0;
    addr_phase(4'h7, 32'h0000_4000, 1, 0);
    tick(); addr_hit_i = 0; loc_rdy_i = 1; #1;
    chk("R2", "medium sel cycle 1", sel_o, 0);
    tick(); loc_rdy_i = 0; #1;
    chk("R2", "medium sel cycle 2", sel_o, 1);
    chk("R6", "trdy raised", trdy_o, 1);
    for (int k = 3; k <= 4; k++) begin
      tick(); #1;
      chk("R6", $sformatf("trdy held while initiator waits, cycle %0d", k), trdy_o, 1);
    end
    tick(); frame_i = 0; irdy_i = 1; #1;
    chk("R7", "held word transfers", xfer_o, 1);
    tick(); quiet(); #1;
    chk("R11", "hold parked ctl_oe", ctl_oe_o, 1);
    chk("R11", "hold parked trdy", trdy_o, 0);
    tick(); #1;
    chk("R11", "hold released ctl_oe", ctl_oe_o, 0);
  endtask

  task automatic t_stop();
    speed_sel = 2'd0; subtr_en = 0;
    addr_phase(4'h7, 32'h0000_5000, 1, 1);
    tick(); addr_hit_i = 0; irdy_i = 1; loc_stop_i = 1; #1;
    chk("R8", "word before stop", xfer_o, 1);
    chk("R8", "stop not yet", stop_o, 0);
    tick(); frame_i = 0; irdy_i = 1; loc_stop_i = 0; loc_rdy_i = 1; #1;
    chk("R8", "stop raised", stop_o, 1);
    chk("R8", "no ready after stop", trdy_o, 0);
    chk("R8", "no word after stop", xfer_o, 0);
    tick(); quiet(); #1;
    chk("R9", "stop ends access, parked ctl_oe", ctl_oe_o, 1);
    chk("R11", "parked stop", stop_o, 0);
    tick(); #1;
    chk("R11", "stop released ctl_oe", ctl_oe_o, 0);
  endtask

  task automatic t_coincide();
    speed_sel = 2'd0; subtr_en = 0;
    addr_phase(4'h7, 32'h0000_6000, 1, 1);
    tick(); addr_hit_i = 0; irdy_i = 0; loc_stop_i = 1; #1;
    chk("R6", "ready before initiator", trdy_o, 1);
    tick(); frame_i = 0; irdy_i = 1; loc_stop_i = 0; #1;
    chk("R9", "stop with last phase", stop_o, 1);
    chk("R9", "ready kept with stop", trdy_o, 1);
    chk("R9", "last word moves", xfer_o, 1);
    tick(); quiet(); #1;
    chk("R9", "no extra cycle, parked", ctl_oe_o, 1);
    chk("R9", "no extra cycle, sel off", sel_o, 0);
    tick(); #1;
    chk("R11", "coincide released", ctl_oe_o, 0);
  endtask

  task automatic t_dac(input logic [31:0] upper, input logic sub);
    speed_sel = 2'd0; subtr_en = sub;
    addr_phase(4'hD, 32'h0000_7000, 0, 0);
    tick(); cmd_i = 4'h7; ad_i = upper; addr_hit_i = 1; #1;
    chk("R10", "no claim on first dual cycle", sel_o, 0);
    if (upper != 0) begin
      tick(); addr_hit_i = 0; #1;
      chk("R10", "dual fast sel", sel_o, 1);
      chk("R10", "dual address", addr_o, {upper, 32'h0000_7000});
      chk("R10", "dual real command", cmd_o, 4'h7);
      wrap_up("R10");
    end else begin
      for (int k = 1; k <= 5; k++) begin
        tick(); addr_hit_i = 0; #1;
        chk("R10", $sformatf("zero upper never claimed cycle %0d", k), sel_o, 0);
      end
      tick(); quiet(); tick(); #1;
      chk("R10", "zero upper ctl_oe", ctl_oe_o, 0);
    end
    subtr_en = 0;
  endtask

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_latency(2'd0, 1);
    t_latency(2'd1, 2);
    t_latency(2'd2, 3);
    t_latency(2'd3, 3);
    t_subtractive();
    t_unclaimed();
    t_read_fast();
    t_burst();
    t_hold();
    t_stop();
    t_coincide();
    t_dac(32'h0000_0001, 0);
    t_dac(32'h0000_0000, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule